// File: doc/BRIEF.md
# Interval Timer with Standby Wait

This block is an 8-bit periodic timer whose input pulses come from a free-running prescaler on the system clock. A two-bit select field in the mode register chooses one of four prescaler taps (by default one pulse every 2^5, 2^7, 2^9 or 2^12 clocks). Each wrap of the counter from all ones to zero sets an interrupt request flag, which stays set until software acknowledges it. Setting the restart bit in a mode write zeroes both the counter and the prescaler, so a full interval starts from a known point.

The same counter also times the oscillator-stabilisation wait after leaving standby. A wake request arms the wait logic, and the next counter wrap produces a single-cycle wait-done pulse that lets the processor restart. The length of the wait is therefore the selected interval.

Top module: `intv_timer`

## Requirements
- R1: After reset the count is 0, the interrupt flag is 0, wait-done is 0 and the mode readback shows select value 3 (the slowest tap).
- R2: Select value k (0..3) picks tap TAPk, with taps in ascending order (defaults 5, 7, 9, 12). After a restart the count reads floor(n / 2^TAPk) mod 256 when n clock edges have passed.
- R3: When the count wraps from 255 to 0 the interrupt flag is set on that same edge. After a restart this happens exactly 256 * 2^TAPk edges later.
- R4: The interrupt flag stays set until `irq_ack` is high at a clock edge. A wrap during the same edge as `irq_ack` leaves the flag set, and a wrap while the flag is already set leaves it set.
- R5: A mode write with bit 2 (restart) set clears the count and the prescaler on that edge, and also loads the select from bits 1:0.
- R6: A mode write with bit 2 clear changes the select and leaves both the count and the prescaler phase untouched.
- R7: The mode readback gives the select in bits 1:0. Bit 2 of the readback always reads 0.
- R8: After `wake_req`, the first counter wrap drives `wait_done` high for exactly one clock, on the same edge that sets the interrupt flag. Later wraps give no pulse unless a new wake request arrives.
- R9: A wrap that happens on the same edge as `wake_req` does not complete the wait. The pulse comes on the next wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 3 | Mode write data: bits 1:0 tap select, bit 2 restart |
| irq_ack | input | 1 | Clears the interrupt request flag |
| wake_req | input | 1 | Standby-release request that arms the wait |
| count | output | CNT_W | Current counter value |
| mode_rd | output | 3 | Mode readback; bit 2 is always 0 |
| irq | output | 1 | Interrupt request flag |
| wait_done | output | 1 | One-cycle end-of-stabilisation-wait pulse |

## Verification
The bench builds the timer with the tap parameters overridden to 1, 2, 3 and 4 and keeps the 8-bit counter. With these values one full wrap takes at most 4096 clocks, so every select can be timed exactly. Wraps, the acknowledge race, and the wake-request race at the wrap edge can all be placed on a chosen edge in a short run. The counter width stays at its default, so the 255-to-0 boundary being checked is the real one.

// File: rtl/intv_pkg.sv
// Shared types and helpers for the interval timer.
// Assumes exactly four prescaler taps, selected by a two-bit field.
package intv_pkg;

    typedef logic [1:0] tap_sel_t;

    localparam tap_sel_t TAP_SEL_SLOWEST = 2'd3;

    // Mode write word: restart flag above the tap select
    typedef struct packed {
        logic     restart;
        tap_sel_t sel;
    } mode_word_t;

    // Largest of four tap exponents, used to size the prescaler
    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/intv_prescaler.sv
// Free-running prescaler that emits one-cycle ticks at the chosen tap.
// A tick is high in the last cycle of every 2^TAPk cycles, counted from a clear.
// Assumes the tap exponents are at least 1 and no larger than 31.
module intv_prescaler
    import intv_pkg::*;
#(
    parameter int TAP0 = 5,
    parameter int TAP1 = 7,
    parameter int TAP2 = 9,
    parameter int TAP3 = 12
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  tap_sel_t sel,
    output logic     tick
);
    localparam int PRE_W = max_of4(TAP0, TAP1, TAP2, TAP3);
    localparam int NUM_TAPS = 4;
    localparam int TAP_A [NUM_TAPS] = '{TAP0, TAP1, TAP2, TAP3};

    logic [PRE_W-1:0]    pre_q;
    logic [NUM_TAPS-1:0] tap_hit;

    // Advance the prescaler, restarting from zero on clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pre_q <= '0;
        else               pre_q <= pre_q + 1'b1;
    end

    // One decode per tap: low TAPk bits all ones
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam logic [PRE_W-1:0] MSK = PRE_W'((64'd1 << TAP_A[g]) - 64'd1);
        assign tap_hit[g] = ((pre_q & MSK) == MSK);
    end

    // Route the selected tap's decode to the counter
    always_comb tick = tap_hit[sel];

endmodule

// File: rtl/intv_counter.sv
// Interval counter that advances on each prescaler tick and reports its wrap.
// A clear has priority over a tick; a wrap is never reported during a clear.
module intv_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    // Wrap happens when a tick meets the all-ones count
    always_comb ovf = tick && (&count) && !clr;

    // Count ticks, with clear taking priority
    always_ff @(posedge clk) begin
        if (!rst_n || clr) count <= '0;
        else if (tick)     count <= count + 1'b1;
    end

endmodule

// File: rtl/intv_irq_wait.sv
// Interrupt request flag and standby-release wait tracking.
// When a wrap and an acknowledge arrive together, the flag stays set.
// A wake request arms the wait; the next wrap after it gives a one-cycle done pulse.
module intv_irq_wait (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic irq_ack,
    input  logic wake_req,
    output logic irq,
    output logic wait_done
);
    logic armed_q;

    // Interrupt flag: set on wrap, cleared by acknowledge, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (ovf)     irq <= 1'b1;
        else if (irq_ack) irq <= 1'b0;
    end

    // Wait arming: a request on a wrap edge waits for the following wrap
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= wake_req || (armed_q && !ovf);
    end

    // Done pulse on the first wrap seen while armed
    always_ff @(posedge clk) begin
        if (!rst_n) wait_done <= 1'b0;
        else        wait_done <= armed_q && ovf;
    end

endmodule

// File: rtl/intv_timer.sv
// Top of the interval timer with standby wait.
// Holds the mode register and connects the prescaler, the counter and the flag/wait logic.
// Assumes mode writes, acknowledges and wake requests are single-clock strobes
// synchronous to clk.
module intv_timer
    import intv_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int TAP0  = 5,
    parameter int TAP1  = 7,
    parameter int TAP2  = 9,
    parameter int TAP3  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_we,
    input  logic [2:0]       mode_wdata,
    input  logic             irq_ack,
    input  logic             wake_req,
    output logic [CNT_W-1:0] count,
    output logic [2:0]       mode_rd,
    output logic             irq,
    output logic             wait_done
);
    mode_word_t wr;
    tap_sel_t   sel_q;
    logic       restart;
    logic       tick;
    logic       ovf;

    // Decode the write word into its restart flag and select field
    always_comb begin
        wr      = mode_word_t'(mode_wdata);
        restart = mode_we && wr.restart;
    end

    // Mode register: only the select is stored, restart is a one-shot
    always_ff @(posedge clk) begin
        if (!rst_n)       sel_q <= TAP_SEL_SLOWEST;
        else if (mode_we) sel_q <= wr.sel;
    end

    // Readback shows the select, with restart always 0
    always_comb mode_rd = {1'b0, sel_q};

    intv_prescaler #(
        .TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2), .TAP3(TAP3)
    ) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (restart),
        .sel  (sel_q),
        .tick (tick)
    );

    intv_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (restart),
        .tick (tick),
        .count(count),
        .ovf  (ovf)
    );

    intv_irq_wait u_iw (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovf      (ovf),
        .irq_ack  (irq_ack),
        .wake_req (wake_req),
        .irq      (irq),
        .wait_done(wait_done)
    );

endmodule

// File: rtl/intv_timer_chk.sv
// Property checker for the interval timer, bound to every instance of the top.
// Watches only the top-level ports.
module intv_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_we,
    input logic [2:0]       mode_wdata,
    input logic             irq_ack,
    input logic [CNT_W-1:0] count,
    input logic [2:0]       mode_rd,
    input logic             irq,
    input logic             wait_done
);
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && mode_wdata[2]) |=> (count == '0)); // R5

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> (mode_rd == {1'b0, $past(mode_wdata[1:0])})); // R7

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_we && mode_wdata[2]) |=> ((CNT_W'(count - $past(count))) <= CNT_W'(1))); // R2

    AST_IRQ_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (($past(count) == {CNT_W{1'b1}}) && (count == '0))); // R3

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq); // R4

    AST_WAIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wait_done |=> !wait_done); // R8

    AST_WAIT_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        wait_done |-> (irq && (count == '0))); // R8

endmodule

bind intv_timer intv_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_we   (mode_we),
    .mode_wdata(mode_wdata),
    .irq_ack   (irq_ack),
    .count     (count),
    .mode_rd   (mode_rd),
    .irq       (irq),
    .wait_done (wait_done)
);

// File: tb/tb_intv_timer.sv
// Directed bench for the interval timer, built with short taps 1, 2, 3 and 4.
module tb_intv_timer;
    localparam int CNT_W = 8;
    localparam int TB_TAP [4] = '{1, 2, 3, 4};
    localparam int WRAP = 1 << CNT_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_we = 1'b0;
    logic [2:0]       mode_wdata = '0;
    logic             irq_ack = 1'b0;
    logic             wake_req = 1'b0;
    logic [CNT_W-1:0] count;
    logic [2:0]       mode_rd;
    logic             irq;
    logic             wait_done;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    intv_timer #(
        .CNT_W(CNT_W), .TAP0(1), .TAP1(2), .TAP2(3), .TAP3(4)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_we   (mode_we),
        .mode_wdata(mode_wdata),
        .irq_ack   (irq_ack),
        .wake_req  (wake_req),
        .count     (count),
        .mode_rd   (mode_rd),
        .irq       (irq),
        .wait_done (wait_done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One mode write; returns at the negedge after the capturing edge
    task automatic write_mode(input int sel, input bit rs);
        mode_we    = 1'b1;
        mode_wdata = {rs, 2'(sel)};
        @(negedge clk);
        mode_we    = 1'b0;
        mode_wdata = '0;
    endtask

    task automatic ack_irq();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        check(count == 0, "R1 count", count, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(wait_done == 1'b0, "R1 wait_done", wait_done, 0);
        check(mode_rd == 3'd3, "R1 mode_rd", mode_rd, 3);
    endtask

    task automatic t_rate(input int sel);
        int p;
        p = 1 << TB_TAP[sel];
        write_mode(sel, 1'b1);
        check(count == 0, "R5 count after restart", count, 0);
        step(5 * p + p - 1);
        check(count == 5, "R2 count before step", count, 5);
        step(1);
        check(count == 6, "R2 count after step", count, 6);
    endtask

    task automatic t_mode_rd();
        write_mode(2, 1'b1);
        check(mode_rd == 3'd2, "R7 readback restart bit", mode_rd, 2);
        write_mode(1, 1'b0);
        check(mode_rd == 3'd1, "R7 readback select", mode_rd, 1);
    endtask

    task automatic t_overflow();
        int p;
        p = 1 << TB_TAP[0];
        if (irq) ack_irq();
        write_mode(0, 1'b1);
        step(WRAP * p - 1);
        check(count == WRAP - 1, "R3 count before wrap", count, WRAP - 1);
        check(irq == 1'b0, "R3 irq before wrap", irq, 0);
        step(1);
        check(irq == 1'b1, "R3 irq at wrap", irq, 1);
        check(count == 0, "R3 count at wrap", count, 0);
        step(WRAP * p);
        check(irq == 1'b1, "R4 irq after second wrap", irq, 1);
        ack_irq();
        check(irq == 1'b0, "R4 irq after ack", irq, 0);
    endtask

    task automatic t_ack_race();
        int p;
        p = 1 << TB_TAP[0];
        write_mode(0, 1'b1);
        step(WRAP * p - 1);
        check(irq == 1'b0, "R4 irq before race", irq, 0);
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;
        check(irq == 1'b1, "R4 wrap beats ack", irq, 1);
        ack_irq();
    endtask

    task automatic t_no_clear_change();
        write_mode(3, 1'b1);
        step(40);
        check(count == 2, "R6 count before select change", count, 2);
        write_mode(0, 1'b0);
        check(count == 2, "R6 count kept on write", count, 2);
        check(mode_rd == 3'd0, "R6 select loaded", mode_rd, 0);
        step(1);
        check(count == 3, "R6 prescaler phase kept", count, 3);
        step(2);
        check(count == 4, "R6 new rate", count, 4);
    endtask

    task automatic t_wait();
        int p;
        int seen;
        p = 1 << TB_TAP[0];
        write_mode(0, 1'b1);
        wake_req = 1'b1;
        step(1);
        wake_req = 1'b0;
        step(WRAP * p - 2);
        check(wait_done == 1'b0, "R8 no pulse before wrap", wait_done, 0);
        step(1);
        check(wait_done == 1'b1, "R8 pulse at wrap", wait_done, 1);
        check(irq == 1'b1, "R8 irq with pulse", irq, 1);
        seen = 0;
        for (int i = 0; i < WRAP * p; i++) begin
            step(1);
            if (wait_done) seen++;
        end
        check(seen == 0, "R8 single pulse only", seen, 0);
        ack_irq();
    endtask

    task automatic t_wake_race();
        int p;
        p = 1 << TB_TAP[0];
        write_mode(0, 1'b1);
        step(WRAP * p - 1);
        wake_req = 1'b1;
        step(1);
        wake_req = 1'b0;
        check(wait_done == 1'b0, "R9 no pulse on coincident wrap", wait_done, 0);
        step(WRAP * p - 1);
        check(wait_done == 1'b0, "R9 no pulse before next wrap", wait_done, 0);
        step(1);
        check(wait_done == 1'b1, "R9 pulse on next wrap", wait_done, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        step(4);
        rst_n = 1'b1;
        t_reset();
        step(1);
        t_reset();
        for (int s = 0; s < 4; s++) t_rate(s);
        t_mode_rd();
        t_overflow();
        t_ack_race();
        t_no_clear_change();
        t_wait();
        t_wake_race();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule